// File: doc/BRIEF.md
# DRAM Self-Refresh Entry and Exit Sequencer

This block moves an EDO DRAM into its low-power self-refresh state when a sleep request arrives and returns it to normal operation when a wake request arrives. It drives the row strobe, column strobe, write enable and output enable pins directly for the whole transition. During this time the memory controller's normal command path is expected to be idle. On entry it pulls the column strobe low before the row strobe falls, with write enable high. It then keeps the row strobe low for a programmable minimum, which is long enough for the device's internal refresh timer to take over.

On exit it raises both strobes and holds a self-refresh precharge interval. After that it issues the catch-up refresh that the refresh policy in use requires. A one-bit policy input is sampled with each sleep request. Policy 0 means refresh has been spread evenly with CAS-before-RAS cycles, so one such cycle follows the exit. Policy 1 covers any other scheme, so a full burst of CAS-before-RAS cycles precedes entry and another follows exit. Every burst cycle reuses one shared cycle engine.

Two status outputs report progress. `busy` flags a transition in progress. `asleep` is raised only once the row strobe has been low for the full minimum, and it drops when the exit refresh is finished. A wake request that arrives before the minimum has elapsed is remembered and acted on afterwards.

Top module: `srf_seq`

## Requirements
- R1: After reset, ras_n, cas_n, we_n and oe_n are 1, and busy and asleep are 0.
- R2: On entry, cas_n is low for at least CSR_CYC clock cycles before ras_n falls, and we_n is high; under policy 0 no refresh cycle comes before entry.
- R3: The self-refresh pulse holds ras_n low for at least RASS_CYC cycles, and asleep rises only after ras_n has been low for that many cycles, while ras_n and cas_n are both low.
- R4: A wake_req that arrives before the minimum hold has elapsed is kept; the block still reaches asleep and then exits without a further request.
- R5: After the self-refresh pulse ends, ras_n stays high for at least RPS_CYC cycles before it falls again.
- R6: With policy 0 sampled at the sleep request, exactly one CAS-before-RAS cycle follows exit, and no other row-strobe pulse occurs.
- R7: With policy 1 sampled at the sleep request, exactly BURST_LEN CAS-before-RAS cycles come before entry and BURST_LEN come after exit, with ras_n high for at least RP_CYC cycles between them; a change of policy after the request has no effect.
- R8: Each CAS-before-RAS cycle has cas_n low for at least CSR_CYC cycles before ras_n falls, and then ras_n low for exactly RAS_CYC cycles.
- R9: we_n and oe_n stay 1 at all times, so the data pins stay in high impedance.
- R10: busy is 1 from the cycle after an accepted sleep request until the sequence ends, except while simply asleep; asleep falls only once the exit refresh has finished, and at that point ras_n and cas_n are 1 and busy is 0.
- R11: sleep_req is ignored unless the block is idle, and wake_req is ignored while idle; neither produces any row-strobe pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Request to enter self-refresh (one-cycle pulse, sampled when idle) |
| wake_req | input | 1 | Request to leave self-refresh (one-cycle pulse) |
| policy | input | 1 | Refresh scheme: 0 = evenly spread CBR, 1 = any other scheme |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low (both byte strobes) |
| we_n | output | 1 | Write enable, active low, held high |
| oe_n | output | 1 | Output enable, active low, held high |
| busy | output | 1 | Entry or exit sequence in progress |
| asleep | output | 1 | Device is in self-refresh or finishing its exit refresh |

## Verification
The bench builds the sequencer with CSR_CYC=2, RAS_CYC=3, RP_CYC=2, RASS_CYC=40, RPS_CYC=6 and BURST_LEN=4. A burst is therefore short enough that a policy-1 session has every one of its pulses classified and counted one by one. The minimum hold is short enough that wake requests can be placed both inside and well past it. With these values, the early-wake hold, a policy change after the request, and a sleep request sent while asleep can all be run in a few hundred cycles each.

// File: rtl/srf_pkg.sv
package srf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE_BURST,
      ST_ENTRY_SETUP,
      ST_HOLD,
      ST_ASLEEP,
      ST_EXIT_PRE,
      ST_POST_REF
   } srf_state_e;

   typedef enum logic [1:0] {
      CB_IDLE,
      CB_SETUP,
      CB_ACT,
      CB_PRE
   } cbr_phase_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/srf_cbr_engine.sv
module srf_cbr_engine
   import srf_pkg::*;
#(
   parameter int CSR_CYC = 1,
   parameter int RAS_CYC = 3,
   parameter int RP_CYC  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic ras_n,
   output logic cas_n,
   output logic done
);
   localparam int CW = $clog2(max3(CSR_CYC, RAS_CYC, RP_CYC) + 1);

   cbr_phase_e    phase;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= CB_IDLE;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (phase)
            CB_IDLE: begin
               if (start) begin
                  phase <= CB_SETUP;
                  cnt   <= CW'(CSR_CYC - 1);
               end
            end
            CB_SETUP: begin
               if (cnt == '0) begin
                  phase <= CB_ACT;
                  cnt   <= CW'(RAS_CYC - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            CB_ACT: begin
               if (cnt == '0) begin
                  phase <= CB_PRE;
                  cnt   <= CW'(RP_CYC - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            CB_PRE: begin
               if (cnt == '0) begin
                  phase <= CB_IDLE;
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: phase <= CB_IDLE;
         endcase
      end
   end

   assign ras_n = (phase != CB_ACT);
   assign cas_n = !((phase == CB_SETUP) || (phase == CB_ACT));

endmodule

// File: rtl/srf_burst_ctr.sv
module srf_burst_ctr #(
   parameter int LEN = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic single,
   input  logic dec,
   output logic last
);
   generate
      if (LEN == 1) begin : g_one
         logic unused_in;
         assign unused_in = ^{clk, rst_n, load, single, dec};
         assign last      = 1'b1;
      end else begin : g_multi
         localparam int BW = $clog2(LEN + 1);
         logic [BW-1:0] rem;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       rem <= BW'(1);
            else if (load)    rem <= single ? BW'(1) : BW'(LEN);
            else if (dec)     rem <= rem - 1'b1;
         end
         assign last = (rem == BW'(1));
      end
   endgenerate

endmodule

// File: rtl/srf_seq.sv
module srf_seq
   import srf_pkg::*;
#(
   parameter int CSR_CYC   = 1,
   parameter int RAS_CYC   = 3,
   parameter int RP_CYC    = 2,
   parameter int RASS_CYC  = 5000,
   parameter int RPS_CYC   = 6,
   parameter int BURST_LEN = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   input  logic wake_req,
   input  logic policy,
   output logic ras_n,
   output logic cas_n,
   output logic we_n,
   output logic oe_n,
   output logic busy,
   output logic asleep
);
   localparam int TW = $clog2(max3(CSR_CYC, RASS_CYC, RPS_CYC) + 1);

   generate
      if (CSR_CYC < 1 || RAS_CYC < 1 || RP_CYC < 1 || RPS_CYC < 1) begin : g_bad_timing
         $error("srf_seq: every timing count must be at least one cycle");
      end
      if (RASS_CYC <= RAS_CYC) begin : g_bad_hold
         $error("srf_seq: RASS_CYC must exceed RAS_CYC");
      end
      if (BURST_LEN < 1) begin : g_bad_burst
         $error("srf_seq: BURST_LEN must be at least one");
      end
   endgenerate

   srf_state_e    state;
   logic [TW-1:0] tmr;
   logic          pol_q;
   logic          wake_pend;

   logic eng_start, eng_ras_n, eng_cas_n, eng_done;
   logic burst_load, burst_single, burst_dec, burst_last;

   // Engine launches: first burst cycle, next burst cycle, and post-exit refresh.
   always_comb begin
      eng_start    = 1'b0;
      burst_load   = 1'b0;
      burst_single = 1'b0;
      burst_dec    = 1'b0;
      case (state)
         ST_IDLE: begin
            if (sleep_req && policy) begin
               eng_start  = 1'b1;
               burst_load = 1'b1;
            end
         end
         ST_PRE_BURST, ST_POST_REF: begin
            if (eng_done && !burst_last) begin
               eng_start = 1'b1;
               burst_dec = 1'b1;
            end
         end
         ST_EXIT_PRE: begin
            if (tmr == '0) begin
               eng_start    = 1'b1;
               burst_load   = 1'b1;
               burst_single = !pol_q;
            end
         end
         default: ;
      endcase
   end

   srf_cbr_engine #(
      .CSR_CYC(CSR_CYC),
      .RAS_CYC(RAS_CYC),
      .RP_CYC (RP_CYC)
   ) u_engine (
      .clk  (clk),
      .rst_n(rst_n),
      .start(eng_start),
      .ras_n(eng_ras_n),
      .cas_n(eng_cas_n),
      .done (eng_done)
   );

   srf_burst_ctr #(
      .LEN(BURST_LEN)
   ) u_burst (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (burst_load),
      .single(burst_single),
      .dec   (burst_dec),
      .last  (burst_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         tmr       <= '0;
         pol_q     <= 1'b0;
         wake_pend <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               wake_pend <= 1'b0;
               if (sleep_req) begin
                  pol_q <= policy;
                  if (policy) begin
                     state <= ST_PRE_BURST;
                  end else begin
                     state <= ST_ENTRY_SETUP;
                     tmr   <= TW'(CSR_CYC - 1);
                  end
               end
            end
            ST_PRE_BURST: begin
               if (wake_req) wake_pend <= 1'b1;
               if (eng_done && burst_last) begin
                  state <= ST_ENTRY_SETUP;
                  tmr   <= TW'(CSR_CYC - 1);
               end
            end
            ST_ENTRY_SETUP: begin
               if (wake_req) wake_pend <= 1'b1;
               if (tmr == '0) begin
                  state <= ST_HOLD;
                  tmr   <= TW'(RASS_CYC - 1);
               end else begin
                  tmr <= tmr - 1'b1;
               end
            end
            ST_HOLD: begin
               if (wake_req) wake_pend <= 1'b1;
               if (tmr == '0) state <= ST_ASLEEP;
               else           tmr   <= tmr - 1'b1;
            end
            ST_ASLEEP: begin
               if (wake_req || wake_pend) begin
                  state     <= ST_EXIT_PRE;
                  tmr       <= TW'(RPS_CYC - 1);
                  wake_pend <= 1'b0;
               end
            end
            ST_EXIT_PRE: begin
               if (tmr == '0) state <= ST_POST_REF;
               else           tmr   <= tmr - 1'b1;
            end
            ST_POST_REF: begin
               if (eng_done && burst_last) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (state)
         ST_PRE_BURST, ST_POST_REF: begin
            ras_n = eng_ras_n;
            cas_n = eng_cas_n;
         end
         ST_ENTRY_SETUP: begin
            ras_n = 1'b1;
            cas_n = 1'b0;
         end
         ST_HOLD, ST_ASLEEP: begin
            ras_n = 1'b0;
            cas_n = 1'b0;
         end
         default: begin
            ras_n = 1'b1;
            cas_n = 1'b1;
         end
      endcase
   end

   assign we_n   = 1'b1;
   assign oe_n   = 1'b1;
   assign asleep = (state == ST_ASLEEP) || (state == ST_EXIT_PRE) || (state == ST_POST_REF);
   assign busy   = (state != ST_IDLE) && (state != ST_ASLEEP);

endmodule

// File: rtl/srf_seq_chk.sv
module srf_seq_chk #(
   parameter int RASS_CYC = 5000,
   parameter int RPS_CYC  = 6
) (
   input logic clk,
   input logic rst_n,
   input logic ras_n,
   input logic cas_n,
   input logic we_n,
   input logic oe_n,
   input logic busy,
   input logic asleep
);
   logic [31:0] lowrun;
   logic [31:0] highrun;
   logic        long_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lowrun    <= '0;
         highrun   <= '0;
         long_prev <= 1'b0;
      end else begin
         lowrun  <= ras_n ? '0 : ((lowrun == '1) ? lowrun : lowrun + 1);
         highrun <= !ras_n ? '0 : ((highrun == '1) ? highrun : highrun + 1);
         if (ras_n && lowrun >= 32'(RASS_CYC)) long_prev <= 1'b1;
         else if (!ras_n && lowrun == '0)      long_prev <= 1'b0;
      end
   end

   p_pins_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      we_n && oe_n);

   p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !asleep) |-> (ras_n && cas_n));

   p_cas_lead_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

   p_hold_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(asleep) |-> (!ras_n && !cas_n && lowrun >= 32'(RASS_CYC)));

   p_exit_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n) && long_prev) |-> (highrun >= 32'(RPS_CYC)));

   p_wake_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(asleep) |-> (ras_n && cas_n && !busy));

endmodule

bind srf_seq srf_seq_chk #(
   .RASS_CYC(RASS_CYC),
   .RPS_CYC (RPS_CYC)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .ras_n (ras_n),
   .cas_n (cas_n),
   .we_n  (we_n),
   .oe_n  (oe_n),
   .busy  (busy),
   .asleep(asleep)
);

// File: tb/srf_seq_tb.sv
module srf_seq_tb;
   localparam int CSR  = 2;
   localparam int RASC = 3;
   localparam int RP   = 2;
   localparam int RASS = 40;
   localparam int RPS  = 6;
   localparam int BL   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_req = 1'b0;
   logic wake_req = 1'b0;
   logic policy = 1'b0;
   logic ras_n, cas_n, we_n, oe_n, busy, asleep;

   always #10 clk = ~clk;

   srf_seq #(
      .CSR_CYC(CSR), .RAS_CYC(RASC), .RP_CYC(RP),
      .RASS_CYC(RASS), .RPS_CYC(RPS), .BURST_LEN(BL)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
      .policy(policy), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
      .busy(busy), .asleep(asleep)
   );

   int    total = 0;
   int    bad = 0;
   int    exp_q[$];
   int    rl = 0, rh = 0, cl = 0, low_cycles = 0;
   bit    pulses_seen = 0, prev_long = 0, prev_ras = 1, prev_asleep = 0;
   bit    saw_asleep = 0, pin_bad = 0, finished = 0;
   string cur_tag = "R6";

   task automatic chk(input bit ok, input string req, input int act,
                      input int expv, input string what);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // Monitor: classifies each row-strobe pulse (0 = CBR, 1 = self-refresh, 2 = bad)
   always @(negedge clk) begin
      if (rst_n) begin
         if (!we_n || !oe_n) pin_bad = 1;
         if (asleep && !prev_asleep) begin
            saw_asleep = 1;
            chk(!ras_n && !cas_n && rl >= RASS, "R3", rl, RASS, "low run at asleep rise");
         end
         if (!asleep && prev_asleep) begin
            chk(exp_q.size() == 0, "R10", exp_q.size(), 0, "pulses left at asleep fall");
            chk(ras_n && cas_n && !busy, "R10", {ras_n, cas_n, busy}, 3'b110, "pins at asleep fall");
         end
         if (!ras_n) begin
            low_cycles++;
            if (prev_ras) begin
               chk(cl >= CSR, "R8", cl, CSR, "cas lead before ras fall");
               if (pulses_seen) begin
                  if (prev_long) chk(rh >= RPS, "R5", rh, RPS, "exit precharge");
                  else           chk(rh >= RP, "R7", rh, RP, "precharge between cycles");
               end
               rl = 0;
            end
            rl++;
         end else begin
            if (!prev_ras) begin
               int code;
               code = (rl == RASC) ? 0 : ((rl >= RASS) ? 1 : 2);
               pulses_seen = 1;
               prev_long = (rl >= RASS);
               if (exp_q.size() == 0) begin
                  chk(0, "R11", code, -1, "unexpected ras pulse");
               end else begin
                  int e;
                  e = exp_q.pop_front();
                  chk(code == e, (e == 1) ? "R3" : cur_tag, code, e, "pulse kind");
               end
               rh = 0;
            end
            rh++;
         end
         cl = cas_n ? 0 : cl + 1;
         prev_ras = ras_n;
         prev_asleep = asleep;
      end
   end

   // Driver: pushes the expected pulse sequence, then stimulates one session.
   task automatic session(input bit pol, input int wake_dly, input bit poke);
      int n;
      cur_tag = pol ? "R7" : "R6";
      if (pol) repeat (BL) exp_q.push_back(0);
      exp_q.push_back(1);
      repeat (pol ? BL : 1) exp_q.push_back(0);
      saw_asleep = 0;
      @(negedge clk);
      policy = pol;
      sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
      policy = !pol;
      chk(busy && !asleep, "R10", {busy, asleep}, 2'b10, "busy after request");
      if (!pol) chk(!cas_n && ras_n, "R2", {ras_n, cas_n}, 2'b10, "cas low first, no burst");
      if (poke) begin
         n = 0;
         while (!asleep && n < 1000) begin @(negedge clk); n++; end
         chk(asleep && !busy, "R10", {busy, asleep}, 2'b01, "resting while asleep");
         sleep_req = 1'b1;
         @(negedge clk);
         sleep_req = 1'b0;
      end
      repeat (wake_dly) @(negedge clk);
      wake_req = 1'b1;
      @(negedge clk);
      wake_req = 1'b0;
      n = 0;
      while (!(saw_asleep && !asleep) && n < 5000) begin @(negedge clk); n++; end
      chk(saw_asleep, "R4", saw_asleep, 1, "reached asleep");
      chk(!asleep && !busy, "R10", {busy, asleep}, 2'b00, "idle after exit");
      chk(exp_q.size() == 0, cur_tag, exp_q.size(), 0, "all expected pulses seen");
      repeat (3) @(negedge clk);
   endtask

   initial begin
      int snap;
      repeat (3) @(negedge clk);
      chk(ras_n && cas_n && we_n && oe_n, "R1", {ras_n, cas_n, we_n, oe_n}, 4'hF, "strobes in reset");
      chk(!busy && !asleep, "R1", {busy, asleep}, 0, "status in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(ras_n && cas_n && !busy && !asleep, "R1", {ras_n, cas_n, busy, asleep}, 4'b1100, "after reset");

      session(1'b0, RASS + 20, 1'b0);   // evenly spread policy, late wake
      session(1'b1, RASS + 60, 1'b0);   // burst policy, late wake
      session(1'b0, 3, 1'b0);           // R4 early wake held
      session(1'b1, 2, 1'b0);           // R4 early wake during pre-entry burst
      session(1'b1, 5, 1'b1);           // R11 sleep_req while asleep ignored

      // R11: wake while idle does nothing
      snap = low_cycles;
      @(negedge clk);
      wake_req = 1'b1;
      @(negedge clk);
      wake_req = 1'b0;
      repeat (30) @(negedge clk);
      chk(low_cycles == snap, "R11", low_cycles - snap, 0, "ras low cycles after idle wake");
      chk(!busy && !asleep, "R11", {busy, asleep}, 0, "still idle after wake");

      chk(!pin_bad, "R9", pin_bad, 0, "we_n/oe_n held high");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule